// File: doc/BRIEF.md
# Framed Synchronous Serial Transmitter

This block is the transmit half of a synchronous serial port for audio and signal-processing samples. A parallel word enters through a valid/ready handshake into a single holding register. At every frame boundary the held word moves into the output stage and is sent one bit per bit-clock period on a serial data line. A frame is `FRAME_BITS` bit periods long. The first `WORD_W` periods carry the word and the rest carry zeros. A frame sync line marks each frame.

Plain input ports set the waveform, and all of them should be at 0 out of reset. They select the sync polarity, the sync type (one word long or one bit long), early or on-time placement of a word-long sync, the shift order, and the bit-clock edge on which data and sync are launched. One further input picks the bit-clock source: an internal divider of the system clock, which is also driven out on the bit-clock pin, or an external bit clock that arrives on an input pin. All logic runs on the system clock. The bit clock is handled as a sampled level whose launch edge is detected, and data and sync change one system cycle after that edge has been seen.

If no word is held when a frame starts, the frame carries zeros and the underrun flag stays high for that frame. The sync is still produced.

Top module: `sync_serial_tx`

## Requirements
- R1: While `rst_ni` is low, `sd_o`, `underrun_o` and `bclk_o` are 0, `tx_ready_o` is 1, and `fs_o` equals `sync_pol_i`.
- R2: When `int_clk_i`=1, `bclk_o` is a square wave with a period of 2×(`div_i`+1) system cycles, and `bclk_oe_o` is 1.
- R3: When `clk_pol_i`=0, `sd_o` and `fs_o` change only one system cycle after a rising edge of the selected bit clock. When `clk_pol_i`=1, they change one system cycle after a falling edge.
- R4: Bit positions in a frame are numbered 0 to `FRAME_BITS`-1. The first launch after reset is position 0. Positions 0 to `WORD_W`-1 carry the word, and all later positions drive `sd_o`=0.
- R5: When `lsb_first_i`=0, position p carries word bit `WORD_W`-1-p (MSB first). When `lsb_first_i`=1, position p carries word bit p (LSB first).
- R6: `sync_len_i` codes 01 and 10 select a one-bit-long sync. Codes 00 and 11 select a word-long sync.
- R7: A word-long sync is active for `WORD_W` bit periods. With `sync_early_i`=0 these are positions 0 to `WORD_W`-1. With `sync_early_i`=1 they are position `FRAME_BITS`-1 of the previous frame and positions 0 to `WORD_W`-2.
- R8: A one-bit-long sync is active only at position `FRAME_BITS`-1, the bit period just before the first data bit. `sync_early_i` has no effect on it.
- R9: `fs_o` is high when the sync is active and `sync_pol_i`=0. It is low when the sync is active and `sync_pol_i`=1.
- R10: `tx_ready_o` is 1 exactly when the holding register is empty. A word taken with `tx_valid_i`&&`tx_ready_o` makes `tx_ready_o` 0 from the next cycle, and that word is sent in the next frame that starts.
- R11: If no word is held at a frame start, that frame carries all zeros, `underrun_o` is 1 for the whole frame, and the sync is still produced. A frame that starts with a held word sets `underrun_o` to 0.
- R12: When `int_clk_i`=0, the bit clock is `bclk_i` after two synchronizing flops, `bclk_oe_o` is 0 and `bclk_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tx_data_i | input | WORD_W | Word to send |
| tx_valid_i | input | 1 | Word on `tx_data_i` is valid |
| tx_ready_o | output | 1 | Holding register empty |
| clk_pol_i | input | 1 | Launch edge select: 0 rising, 1 falling |
| sync_pol_i | input | 1 | Sync polarity: 0 active high, 1 active low |
| sync_early_i | input | 1 | Word-long sync starts one bit early |
| sync_len_i | input | 2 | Sync type code |
| lsb_first_i | input | 1 | Shift order: 1 LSB first |
| int_clk_i | input | 1 | Bit clock source: 1 internal divider, 0 `bclk_i` |
| div_i | input | DIV_W | Internal divider value |
| bclk_i | input | 1 | External bit clock |
| bclk_o | output | 1 | Internal bit clock out |
| bclk_oe_o | output | 1 | Output enable for the bit-clock pin |
| sd_o | output | 1 | Serial data |
| fs_o | output | 1 | Frame sync |
| underrun_o | output | 1 | Current frame started with no word held |

## Verification
The hardest cases to reach are those at the frame seam. An early word-long sync has to rise on the last idle bit of the previous frame. A frame with no word has to be told apart from a frame that carries a real all-zero word. To reach these, every configuration runs several frames back to back. Words are offered only in the idle tail of a frame and are withheld at random, so data frames and underrun frames follow each other in mixed order. Directed runs cover every sync code, both polarities, both launch edges, both shift orders and both clock sources, and a few random configurations are added on top.

// File: rtl/sst_pkg.sv
package sst_pkg;

  typedef enum logic {
    SYNC_WORD = 1'b0,
    SYNC_BIT  = 1'b1
  } sync_kind_e;

  // codes 01 and 10 give a bit-long sync, 00 and 11 a word-long one
  function automatic sync_kind_e decode_sync_len(input logic [1:0] code);
    return (code[1] ^ code[0]) ? SYNC_BIT : SYNC_WORD;
  endfunction

endpackage

// File: rtl/sst_bclk_gen.sv
module sst_bclk_gen #(
  parameter int unsigned DIV_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             int_clk_i,
  input  logic             clk_pol_i,
  input  logic [DIV_W-1:0] div_i,
  input  logic             bclk_i,
  output logic             bclk_o,
  output logic             launch_o
);

  logic [DIV_W-1:0] div_cnt_q;
  logic             bclk_int_q;
  logic [1:0]       ext_sync_q;
  logic             bsel_d_q;
  logic             bsel;
  logic             rise;
  logic             fall;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      div_cnt_q  <= '0;
      bclk_int_q <= 1'b0;
    end else if (!int_clk_i) begin
      div_cnt_q  <= '0;
      bclk_int_q <= 1'b0;
    end else if (div_cnt_q >= div_i) begin
      div_cnt_q  <= '0;
      bclk_int_q <= ~bclk_int_q;
    end else begin
      div_cnt_q  <= div_cnt_q + DIV_W'(1);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ext_sync_q <= '0;
      bsel_d_q   <= 1'b0;
    end else begin
      ext_sync_q <= {ext_sync_q[0], bclk_i};
      bsel_d_q   <= bsel;
    end
  end

  assign bsel     = int_clk_i ? bclk_int_q : ext_sync_q[1];
  assign rise     = bsel & ~bsel_d_q;
  assign fall     = ~bsel & bsel_d_q;
  assign launch_o = clk_pol_i ? fall : rise;
  assign bclk_o   = bclk_int_q;

  AST_DIV_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int_clk_i && (div_cnt_q < div_i) |=> $stable(bclk_o)); // R2

  AST_EXT_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !int_clk_i |=> !bclk_o); // R12

endmodule

// File: rtl/sst_frame_ctrl.sv
module sst_frame_ctrl
  import sst_pkg::*;
#(
  parameter int unsigned WORD_W     = 16,
  parameter int unsigned FRAME_BITS = 32,
  localparam int unsigned POS_W     = $clog2(FRAME_BITS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             launch_i,
  input  sync_kind_e       kind_i,
  input  logic             early_i,
  output logic [POS_W-1:0] pos_o,
  output logic [POS_W-1:0] next_pos_o,
  output logic             frame_start_o,
  output logic             fs_act_o
);

  localparam logic [POS_W-1:0] LAST_POS = POS_W'(FRAME_BITS - 1);
  localparam logic [POS_W-1:0] WORD_END = POS_W'(WORD_W);
  localparam logic [POS_W-1:0] EARLY_END = POS_W'(WORD_W - 1);

  logic [POS_W-1:0] pos_q;
  logic             fs_act_q;
  logic             fs_next;

  assign next_pos_o    = (pos_q == LAST_POS) ? '0 : pos_q + POS_W'(1);
  assign frame_start_o = launch_i && (pos_q == LAST_POS);

  always_comb begin
    if (kind_i == SYNC_BIT)  fs_next = (next_pos_o == LAST_POS);
    else if (early_i)        fs_next = (next_pos_o == LAST_POS) || (next_pos_o < EARLY_END);
    else                     fs_next = (next_pos_o < WORD_END);
  end

  // reset to the last position so the first launch opens a frame
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pos_q    <= LAST_POS;
      fs_act_q <= 1'b0;
    end else if (launch_i) begin
      pos_q    <= next_pos_o;
      fs_act_q <= fs_next;
    end
  end

  assign pos_o    = pos_q;
  assign fs_act_o = fs_act_q;

  AST_POS_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    launch_i && (pos_q == LAST_POS) |=> (pos_q == '0)); // R4

  AST_FS_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !launch_i |=> $stable(fs_act_o)); // R3

  AST_BIT_SYNC_ONLY_LAST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    launch_i && (kind_i == SYNC_BIT) && (pos_q != (LAST_POS - POS_W'(1))) |=> !fs_act_o); // R8

endmodule

// File: rtl/sst_tx_datapath.sv
module sst_tx_datapath #(
  parameter int unsigned WORD_W     = 16,
  parameter int unsigned FRAME_BITS = 32,
  localparam int unsigned POS_W     = $clog2(FRAME_BITS),
  localparam int unsigned SEL_W     = $clog2(WORD_W)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [WORD_W-1:0] data_i,
  input  logic              valid_i,
  output logic              ready_o,
  input  logic              launch_i,
  input  logic              frame_start_i,
  input  logic [POS_W-1:0]  next_pos_i,
  input  logic              lsb_first_i,
  output logic              sd_o,
  output logic              underrun_o
);

  localparam logic [POS_W-1:0] WORD_END = POS_W'(WORD_W);
  localparam logic [SEL_W-1:0] TOP_BIT  = SEL_W'(WORD_W - 1);

  logic [WORD_W-1:0] hold_q;
  logic              hold_full_q;
  logic [WORD_W-1:0] word_q;
  logic [WORD_W-1:0] new_word;
  logic [WORD_W-1:0] src_word;
  logic [SEL_W-1:0]  bit_idx;
  logic              sd_q;
  logic              underrun_q;
  logic              accept;

  assign ready_o  = ~hold_full_q;
  assign accept   = valid_i && ready_o;
  assign new_word = hold_full_q ? hold_q : '0;
  assign src_word = frame_start_i ? new_word : word_q;
  assign bit_idx  = lsb_first_i ? next_pos_i[SEL_W-1:0] : TOP_BIT - next_pos_i[SEL_W-1:0];

  // accept only happens when empty, so it never collides with a pending word
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_q      <= '0;
      hold_full_q <= 1'b0;
    end else if (accept) begin
      hold_q      <= data_i;
      hold_full_q <= 1'b1;
    end else if (frame_start_i) begin
      hold_full_q <= 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      word_q     <= '0;
      underrun_q <= 1'b0;
    end else if (frame_start_i) begin
      word_q     <= new_word;
      underrun_q <= ~hold_full_q;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sd_q <= 1'b0;
    end else if (launch_i) begin
      sd_q <= (next_pos_i < WORD_END) ? src_word[bit_idx] : 1'b0;
    end
  end

  assign sd_o       = sd_q;
  assign underrun_o = underrun_q;

  AST_ACCEPT_BLOCKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && ready_o |=> !ready_o); // R10

  AST_UNDERRUN_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_start_i && ready_o |=> underrun_o && !sd_o); // R11

  AST_IDLE_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    launch_i && (next_pos_i >= WORD_END) |=> !sd_o); // R4

  AST_SD_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !launch_i |=> $stable(sd_o)); // R3

endmodule

// File: rtl/sync_serial_tx.sv
module sync_serial_tx
  import sst_pkg::*;
#(
  parameter int unsigned WORD_W     = 16,
  parameter int unsigned FRAME_BITS = 32,
  parameter int unsigned DIV_W      = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [WORD_W-1:0] tx_data_i,
  input  logic              tx_valid_i,
  output logic              tx_ready_o,
  input  logic              clk_pol_i,
  input  logic              sync_pol_i,
  input  logic              sync_early_i,
  input  logic [1:0]        sync_len_i,
  input  logic              lsb_first_i,
  input  logic              int_clk_i,
  input  logic [DIV_W-1:0]  div_i,
  input  logic              bclk_i,
  output logic              bclk_o,
  output logic              bclk_oe_o,
  output logic              sd_o,
  output logic              fs_o,
  output logic              underrun_o
);

  localparam int unsigned POS_W = $clog2(FRAME_BITS);

  logic             launch;
  logic [POS_W-1:0] pos;
  logic [POS_W-1:0] next_pos;
  logic             frame_start;
  logic             fs_act;
  sync_kind_e       kind;

  assign kind = decode_sync_len(sync_len_i);

  sst_bclk_gen #(
    .DIV_W (DIV_W)
  ) i_bclk_gen (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .int_clk_i (int_clk_i),
    .clk_pol_i (clk_pol_i),
    .div_i     (div_i),
    .bclk_i    (bclk_i),
    .bclk_o    (bclk_o),
    .launch_o  (launch)
  );

  sst_frame_ctrl #(
    .WORD_W     (WORD_W),
    .FRAME_BITS (FRAME_BITS)
  ) i_frame_ctrl (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .launch_i      (launch),
    .kind_i        (kind),
    .early_i       (sync_early_i),
    .pos_o         (pos),
    .next_pos_o    (next_pos),
    .frame_start_o (frame_start),
    .fs_act_o      (fs_act)
  );

  sst_tx_datapath #(
    .WORD_W     (WORD_W),
    .FRAME_BITS (FRAME_BITS)
  ) i_datapath (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .data_i        (tx_data_i),
    .valid_i       (tx_valid_i),
    .ready_o       (tx_ready_o),
    .launch_i      (launch),
    .frame_start_i (frame_start),
    .next_pos_i    (next_pos),
    .lsb_first_i   (lsb_first_i),
    .sd_o          (sd_o),
    .underrun_o    (underrun_o)
  );

  assign fs_o      = fs_act ^ sync_pol_i;
  assign bclk_oe_o = int_clk_i;

  AST_FRAME_START_LOADS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_start |=> (pos == '0)); // R4

  AST_UNDERRUN_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !frame_start |=> $stable(underrun_o)); // R11

endmodule

// File: tb/test_sync_serial_tx.sv
module test_sync_serial_tx;

  localparam int CLK_PERIOD = 10;
  localparam int W          = 16;
  localparam int F          = 32;
  localparam int DW         = 8;
  localparam int EXT_HALF   = 6;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic [W-1:0]  tx_data_i = '0;
  logic          tx_valid_i = 1'b0;
  logic          tx_ready_o;
  logic          clk_pol_i = 1'b0;
  logic          sync_pol_i = 1'b0;
  logic          sync_early_i = 1'b0;
  logic [1:0]    sync_len_i = 2'b00;
  logic          lsb_first_i = 1'b0;
  logic          int_clk_i = 1'b1;
  logic [DW-1:0] div_i = '0;
  logic          bclk_i = 1'b0;
  logic          bclk_o;
  logic          bclk_oe_o;
  logic          sd_o;
  logic          fs_o;
  logic          underrun_o;

  int  n_checks = 0;
  int  n_errors = 0;
  bit  drop_valid = 1'b0;
  bit  cur_lvl = 1'b0;
  bit  first_bit = 1'b1;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  sync_serial_tx #(
    .WORD_W     (W),
    .FRAME_BITS (F),
    .DIV_W      (DW)
  ) i_sync_serial_tx (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .tx_data_i    (tx_data_i),
    .tx_valid_i   (tx_valid_i),
    .tx_ready_o   (tx_ready_o),
    .clk_pol_i    (clk_pol_i),
    .sync_pol_i   (sync_pol_i),
    .sync_early_i (sync_early_i),
    .sync_len_i   (sync_len_i),
    .lsb_first_i  (lsb_first_i),
    .int_clk_i    (int_clk_i),
    .div_i        (div_i),
    .bclk_i       (bclk_i),
    .bclk_o       (bclk_o),
    .bclk_oe_o    (bclk_oe_o),
    .sd_o         (sd_o),
    .fs_o         (fs_o),
    .underrun_o   (underrun_o)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic finish_sim();
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  endtask

  function automatic bit exp_fs(int p, bit [1:0] len, bit early, bit spol);
    bit act;
    if (len[1] ^ len[0])  act = (p == F-1);
    else if (early)       act = (p == F-1) || (p < W-1);
    else                  act = (p < W);
    return act ^ spol;
  endfunction

  function automatic bit exp_sd(int p, bit [W-1:0] word, bit lsb);
    if (p >= W) return 1'b0;
    return lsb ? word[p] : word[W-1-p];
  endfunction

  task automatic tick();
    @(negedge clk_i);
    if (drop_valid) begin
      tx_valid_i = 1'b0;
      drop_valid = 1'b0;
    end
  endtask

  // returns one system cycle after the launch edge, when outputs are settled
  task automatic next_bit(input string tag);
    if (int_clk_i) begin
      int  cyc = 0;
      bit  prev;
      forever begin
        tick();
        cyc++;
        prev    = cur_lvl;
        cur_lvl = bclk_o;
        if ((!clk_pol_i && !prev && cur_lvl) || (clk_pol_i && prev && !cur_lvl)) break;
      end
      tick();
      cyc++;
      cur_lvl = bclk_o;
      if (!first_bit)
        chk(cyc == 2*(int'(div_i)+1), "R2", {tag, " bit clock period"}, cyc, 2*(int'(div_i)+1));
      chk(bclk_oe_o == 1'b1, "R2", {tag, " clock enable"}, bclk_oe_o, 1);
    end else begin
      if (!first_bit) begin
        bclk_i = ~bclk_i;
        repeat (EXT_HALF) tick();
      end
      bclk_i = ~bclk_i;
      repeat (EXT_HALF) tick();
      chk(bclk_oe_o == 1'b0 && bclk_o == 1'b0, "R12", {tag, " pin released"},
          {bclk_oe_o, bclk_o}, 0);
    end
    first_bit = 1'b0;
  endtask

  task automatic run_cfg(input string tag, input bit pol, input bit spol, input bit early,
                         input bit [1:0] len, input bit lsb, input bit intc,
                         input int div, input int nfr);
    bit [W-1:0] cur_word = '0;
    bit [W-1:0] next_word = '0;
    bit         next_ok = 1'b0;
    bit         cur_under;
    bit         bitk;
    @(negedge clk_i);
    rst_ni       = 1'b0;
    tx_valid_i   = 1'b0;
    drop_valid   = 1'b0;
    clk_pol_i    = pol;
    sync_pol_i   = spol;
    sync_early_i = early;
    sync_len_i   = len;
    lsb_first_i  = lsb;
    int_clk_i    = intc;
    div_i        = DW'(div);
    bclk_i       = pol;
    bitk         = len[1] ^ len[0];
    repeat (3) @(negedge clk_i);
    // R1 reset state
    chk(sd_o == 1'b0, "R1", {tag, " reset sd"}, sd_o, 0);
    chk(underrun_o == 1'b0, "R1", {tag, " reset underrun"}, underrun_o, 0);
    chk(tx_ready_o == 1'b1, "R1", {tag, " reset ready"}, tx_ready_o, 1);
    chk(bclk_o == 1'b0, "R1", {tag, " reset bclk"}, bclk_o, 0);
    chk(fs_o == spol, "R1", {tag, " reset fs"}, fs_o, spol);
    rst_ni    = 1'b1;
    cur_lvl   = 1'b0;
    first_bit = 1'b1;
    if (!intc) repeat (4) tick();
    for (int fr = 0; fr < nfr; fr++) begin
      for (int p = 0; p < F; p++) begin
        next_bit(tag);
        if (p == 0) begin
          cur_word  = next_ok ? next_word : '0;
          cur_under = !next_ok;
          next_ok   = 1'b0;
          chk(underrun_o == cur_under, "R11", {tag, " underrun flag"}, underrun_o, cur_under);
        end
        if (p < W)
          chk(sd_o == exp_sd(p, cur_word, lsb), "R5", $sformatf("%s data pos %0d", tag, p),
              sd_o, exp_sd(p, cur_word, lsb));
        else
          chk(sd_o == 1'b0, "R4", $sformatf("%s idle pos %0d", tag, p), sd_o, 0);
        chk(fs_o == exp_fs(p, len, early, spol), bitk ? "R8" : "R7",
            $sformatf("%s sync pos %0d", tag, p), fs_o, exp_fs(p, len, early, spol));
        if (p == W && (fr == 0 || ($urandom % 4) != 0)) begin
          chk(tx_ready_o == 1'b1, "R10", {tag, " ready when empty"}, tx_ready_o, 1);
          next_word  = W'($urandom);
          if (($urandom % 8) == 0) next_word = '0;
          tx_data_i  = next_word;
          tx_valid_i = 1'b1;
          drop_valid = 1'b1;
          next_ok    = 1'b1;
        end
        if (p == W+2 && next_ok)
          chk(tx_ready_o == 1'b0, "R10", {tag, " full blocks ready"}, tx_ready_o, 0);
      end
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    n_errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_sim();
  end

  initial begin
    void'($urandom(32'd20240));
    //      tag                pol spol early len   lsb int div fr
    run_cfg("R3 R5 R7 msb",    0,  0,   0,    2'b00, 0,  1,  1,  4);
    run_cfg("R3 R5 fall lsb",  1,  0,   0,    2'b00, 1,  1,  0,  4);
    run_cfg("R7 early word",   0,  0,   1,    2'b00, 0,  1,  2,  4);
    run_cfg("R6 R8 code01",    0,  0,   0,    2'b01, 0,  1,  1,  3);
    run_cfg("R6 R8 code10",    1,  0,   1,    2'b10, 1,  1,  3,  3);
    run_cfg("R6 R9 code11",    0,  1,   0,    2'b11, 0,  1,  0,  3);
    run_cfg("R9 R7 early low", 1,  1,   1,    2'b00, 1,  1,  1,  3);
    run_cfg("R12 ext rise",    0,  0,   0,    2'b00, 0,  0,  0,  3);
    run_cfg("R12 R3 ext fall", 1,  1,   0,    2'b01, 1,  0,  0,  3);
    for (int k = 0; k < 4; k++) begin
      run_cfg($sformatf("R11 random %0d", k), 1'($urandom), 1'($urandom), 1'($urandom),
              2'($urandom), 1'($urandom), 1'($urandom), int'($urandom % 4), 3);
    end
    finish_sim();
  end

endmodule